// File: doc/BRIEF.md
# Frame Sync Protection Controller

This block keeps frame alignment for a broadcast data stream that arrives as a sequence of fixed-size blocks. A block counter runs freely on a block tick and wraps at the frame length. Four evenly spaced positions in each frame are checkpoints, where an upstream detector is expected to strobe because the block identification code bends there. At every checkpoint the block compares the strobe with its own timing. Two hysteresis counters then decide whether to declare sync or to give it up: a back counter while hunting and a forward counter while locked.

Both thresholds live in one byte-wide protection register. Each field is programmed as the wanted count minus one. A level-held resync input clears the lock state and all counters but leaves the register untouched. While it is held, the interrupt path is gated off and the serial data line is forced high. A change of the frame-structure selection while locked does not drop sync at once. Instead, the following checkpoints are treated as misses, so sync is lost only after the forward count has run out.

Top module: `frame_sync_ctrl`

## Requirements
- R1: After reset the protection register holds 0x17 (back value 1, forward value 7), `frm_locked` is 0, `frm_phase` is 0, `int_en` is 1 and `dout_hi` is 0.
- R2: The block position advances by one on each `blk_tick` and wraps at FRAME_BLKS (default 16). A checkpoint is every position that is a multiple of FRAME_BLKS/4, and `frm_phase` equals position divided by FRAME_BLKS/4. Without a tick the position holds.
- R3: While hunting, a `mark_det` strobe with a tick at a non-checkpoint position realigns the counter. That tick is taken as checkpoint 0, the position after it is 1, and the realign counts as the first match.
- R4: While hunting, a strobe at a checkpoint adds one match. `frm_locked` rises at the tick where the match count exceeds the back value. A checkpoint without a strobe clears the match count.
- R5: While locked, each checkpoint without a strobe adds one miss, and a checkpoint with a strobe clears the miss count. `frm_locked` falls at the tick where the miss count exceeds the forward value. Strobes at non-checkpoint positions have no effect while locked.
- R6: A write with `cfg_we`=1 loads `cfg_wdata`: bits 7:4 are the back value and bits 3:0 are the forward value. The new values govern every following tick.
- R7: While `resync_hold` is 1, the lock state, the match and miss counts and the position are cleared on every clock, and ticks and strobes are ignored. The protection register keeps its contents.
- R8: `int_en` is the inverse of `resync_hold` and `dout_hi` follows `resync_hold`, both without a clock delay.
- R9: A toggle of `layout_sel` seen while locked makes every later checkpoint count as a miss, even with a strobe, so sync drops after forward value + 1 checkpoints. A toggle while hunting has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_tick | input | 1 | One-cycle pulse per received block |
| mark_det | input | 1 | Inflection detected in this block, valid with `blk_tick` |
| cfg_we | input | 1 | Protection register write strobe |
| cfg_wdata | input | 8 | Protection register write data: back value in 7:4, forward value in 3:0 |
| resync_hold | input | 1 | Level-held synchronization reset |
| layout_sel | input | 1 | Frame-structure selection; a toggle is a structure change |
| frm_locked | output | 1 | Frame synchronized |
| frm_phase | output | 2 | Current quarter of the frame (checkpoint index) |
| int_en | output | 1 | Interrupt path enable |
| dout_hi | output | 1 | Force serial data output high |

## Verification
Lock status and phase are registered. They change on the clock edge that samples a tick, so each result is due one edge after its stimulus. The driver task raises a tick on a falling edge and pushes the expected pair right after the next rising edge. The monitor pops and compares on the following falling edge, when no output can move. A register write, a layout toggle or a hold takes effect on the first rising edge after it is driven, and the model is updated at that same edge. The two gating outputs follow the hold input directly and are checked one time step after it changes.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int PROT_W = 4;
  localparam int CNT_W  = PROT_W + 1;

  typedef enum logic {ST_HUNT = 1'b0, ST_LOCK = 1'b1} fsp_state_e;

  // saturating increment of a protection count
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return (&c) ? c : c + 1'b1;
  endfunction

  // a count passes its programmed value (value = wanted count - 1)
  function automatic logic over_limit(input logic [CNT_W-1:0] c,
                                      input logic [PROT_W-1:0] lim);
    return c > {1'b0, lim};
  endfunction
endpackage

// File: rtl/fsp_cfg_reg.sv
module fsp_cfg_reg
  import fsp_pkg::*;
#(
  parameter logic [2*PROT_W-1:0] RST_VAL = 8'h17
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [2*PROT_W-1:0]   wdata,
  output logic [PROT_W-1:0]     back_val,
  output logic [PROT_W-1:0]     fwd_val
);
  logic [2*PROT_W-1:0] prot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  prot_q <= RST_VAL;
    else if (we) prot_q <= wdata;
  end

  assign back_val = prot_q[2*PROT_W-1:PROT_W];
  assign fwd_val  = prot_q[PROT_W-1:0];

  // R6
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> {back_val, fwd_val} == $past(wdata));
endmodule

// File: rtl/fsp_phase_ctr.sv
module fsp_phase_ctr #(
  parameter int FRAME_BLKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       tick,
  input  logic       realign,
  output logic       on_cp,
  output logic [1:0] phase
);
  localparam int POS_W = $clog2(FRAME_BLKS);
  localparam int QTR   = FRAME_BLKS / 4;
  localparam int QTR_W = $clog2(QTR);

  logic [POS_W-1:0] pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos <= '0;
    else if (clear)  pos <= '0;
    else if (tick)   pos <= realign ? POS_W'(1) : pos + 1'b1;
  end

  assign on_cp = (pos[QTR_W-1:0] == '0);
  assign phase = pos[POS_W-1 -: 2];

  // R2
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !tick) |=> $stable(pos));
  // R3
  realign_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && tick && realign) |=> pos == POS_W'(1));
  // R7
  clear_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> pos == '0);
endmodule

// File: rtl/fsp_lock_fsm.sv
module fsp_lock_fsm
  import fsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              tick,
  input  logic              mark,
  input  logic              on_cp,
  input  logic              layout_chg,
  input  logic [PROT_W-1:0] back_val,
  input  logic [PROT_W-1:0] fwd_val,
  output logic              locked,
  output logic              realign
);
  fsp_state_e       state;
  logic [CNT_W-1:0] hit_cnt, miss_cnt, hunt_next, miss_next;
  logic             pend;
  logic             ev_hunt_hit, ev_hunt_miss, ev_lock_ok, ev_lock_miss;
  logic             ev_acquire, ev_drop, cp_good;

  assign locked       = (state == ST_LOCK);
  assign cp_good      = mark & ~pend;
  assign realign      = tick & ~locked & mark & ~on_cp & ~clear;
  assign ev_hunt_hit  = tick & ~locked & mark & on_cp;
  assign ev_hunt_miss = tick & ~locked & ~mark & on_cp;
  assign ev_lock_ok   = tick & locked & on_cp & cp_good;
  assign ev_lock_miss = tick & locked & on_cp & ~cp_good;

  assign hunt_next  = realign ? CNT_W'(1) : bump(hit_cnt);
  assign miss_next  = bump(miss_cnt);
  assign ev_acquire = (realign | ev_hunt_hit) & over_limit(hunt_next, back_val);
  assign ev_drop    = ev_lock_miss & over_limit(miss_next, fwd_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HUNT; hit_cnt <= '0; miss_cnt <= '0; pend <= 1'b0;
    end else if (clear) begin
      state <= ST_HUNT; hit_cnt <= '0; miss_cnt <= '0; pend <= 1'b0;
    end else begin
      if (ev_acquire) begin
        state   <= ST_LOCK;
        hit_cnt <= '0;
      end else if (realign || ev_hunt_hit) begin
        hit_cnt <= hunt_next;
      end else if (ev_hunt_miss) begin
        hit_cnt <= '0;
      end

      if (ev_drop) begin
        state    <= ST_HUNT;
        miss_cnt <= '0;
      end else if (ev_lock_miss) begin
        miss_cnt <= miss_next;
      end else if (ev_lock_ok) begin
        miss_cnt <= '0;
      end

      if (ev_drop)                  pend <= 1'b0;
      else if (locked && layout_chg) pend <= 1'b1;
    end
  end

  // R4
  acquire_on_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(tick && mark && !clear));
  // R5
  drop_on_cp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(locked) && !$past(clear)) |-> $past(tick && on_cp));
  // R4
  hunt_cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> hit_cnt == '0);
  // R9
  hunt_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (miss_cnt == '0 && !pend));
endmodule

// File: rtl/frame_sync_ctrl.sv
module frame_sync_ctrl
  import fsp_pkg::*;
#(
  parameter int FRAME_BLKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       blk_tick,
  input  logic       mark_det,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic       resync_hold,
  input  logic       layout_sel,
  output logic       frm_locked,
  output logic [1:0] frm_phase,
  output logic       int_en,
  output logic       dout_hi
);
  logic [PROT_W-1:0] back_val, fwd_val;
  logic              on_cp, realign, layout_q, layout_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) layout_q <= 1'b0;
    else        layout_q <= layout_sel;
  end
  assign layout_chg = layout_sel ^ layout_q;

  fsp_cfg_reg #(.RST_VAL(8'h17)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .back_val(back_val), .fwd_val(fwd_val)
  );

  fsp_phase_ctr #(.FRAME_BLKS(FRAME_BLKS)) u_phase (
    .clk(clk), .rst_n(rst_n), .clear(resync_hold), .tick(blk_tick),
    .realign(realign), .on_cp(on_cp), .phase(frm_phase)
  );

  fsp_lock_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .clear(resync_hold), .tick(blk_tick),
    .mark(mark_det), .on_cp(on_cp), .layout_chg(layout_chg),
    .back_val(back_val), .fwd_val(fwd_val),
    .locked(frm_locked), .realign(realign)
  );

  assign int_en  = ~resync_hold;
  assign dout_hi = resync_hold;

  // R7
  hold_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync_hold |=> (!frm_locked && frm_phase == 2'd0));
endmodule

// File: tb/tb_frame_sync_ctrl.sv
`timescale 1ns/1ps
module tb_frame_sync_ctrl;
  localparam int N = 16;
  localparam int Q = N / 4;

  logic clk = 0, rst_n = 0;
  logic blk_tick = 0, mark_det = 0, cfg_we = 0, resync_hold = 0, layout_sel = 0;
  logic [7:0] cfg_wdata = 0;
  logic frm_locked, int_en, dout_hi;
  logic [1:0] frm_phase;

  frame_sync_ctrl #(.FRAME_BLKS(N)) dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  // reference model state
  int m_pos = 0, m_hit = 0, m_miss = 0, m_back = 1, m_fwd = 7;
  bit m_lock = 0, m_pend = 0, m_hold = 0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(input string tg, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tg, act, exp);
    end
  endtask

  task automatic model_step(input bit mk);
    bit cp;
    if (m_hold) return;
    cp = (m_pos % Q) == 0;
    if (!m_lock) begin
      if (mk && !cp) begin m_hit = 1; m_pos = 1; end
      else begin
        if (cp) m_hit = mk ? m_hit + 1 : 0;
        m_pos = (m_pos + 1) % N;
      end
      if (mk && m_hit > m_back) begin m_lock = 1; m_hit = 0; end
    end else begin
      if (cp) begin
        if (mk && !m_pend) m_miss = 0; else m_miss++;
        if (m_miss > m_fwd) begin m_lock = 0; m_miss = 0; m_pend = 0; end
      end
      m_pos = (m_pos + 1) % N;
    end
  endtask

  // driver: one block tick, expected result queued for the monitor
  task automatic tick(input bit mk, input string tg);
    @(negedge clk); blk_tick = 1; mark_det = mk;
    @(posedge clk);
    model_step(mk);
    exp_q.push_back({m_lock, 2'(m_pos / Q)});
    tag_q.push_back(tg);
    @(negedge clk); blk_tick = 0; mark_det = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({t, " locked"}, int'(frm_locked), int'(e[2]));
      chk({t, " phase"}, int'(frm_phase), int'(e[1:0]));
    end
  end

  task automatic run_cp(input int n, input bit at_cp, input bit off_cp, input string tg);
    for (int i = 0; i < n; i++)
      tick(((m_pos % Q) == 0) ? at_cp : off_cp, tg);
  endtask

  task automatic acquire(input string tg);
    if ((m_pos % Q) == 0) tick(0, tg);
    tick(1, tg);
    run_cp(Q * m_back, 1, 0, tg);
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(posedge clk); m_back = v[7:4]; m_fwd = v[3:0];
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic flip_layout();
    @(negedge clk); layout_sel = ~layout_sel;
    @(posedge clk); if (m_lock) m_pend = 1;
    @(negedge clk);
  endtask

  task automatic set_hold(input bit v);
    @(negedge clk); resync_hold = v;
    #1;
    chk("R8 int_en", int'(int_en), int'(!v));
    chk("R8 dout_hi", int'(dout_hi), int'(v));
    @(posedge clk);
    m_hold = v;
    if (v) begin m_lock = 0; m_hit = 0; m_miss = 0; m_pend = 0; m_pos = 0; end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 locked", int'(frm_locked), 0);
    chk("R1 phase", int'(frm_phase), 0);
    chk("R1 int_en", int'(int_en), 1);
    chk("R1 dout_hi", int'(dout_hi), 0);

    // R2 free run, no strobes
    run_cp(21, 0, 0, "R2");
    // R3 off-checkpoint strobe realigns, R1 default back count of 2
    tick(1, "R3");
    chk("R3 phase after realign", int'(frm_phase), 0);
    run_cp(Q, 1, 0, "R1");
    chk("R4 lock with default", int'(frm_locked), 1);

    // R5 stray strobes ignored, interleaved misses and hits keep lock
    run_cp(16, 1, 1, "R5");
    run_cp(5 * Q, 0, 0, "R5");
    run_cp(Q, 1, 0, "R5");
    run_cp(5 * Q, 0, 0, "R5");
    chk("R5 still locked", int'(frm_locked), 1);
    run_cp(10 * Q, 0, 0, "R5");
    chk("R5 lost lock", int'(frm_locked), 0);

    // R4 a missed checkpoint clears the match count while hunting
    tick(0, "R4"); tick(1, "R4");
    run_cp(Q, 0, 0, "R4");
    run_cp(Q, 1, 0, "R4");
    chk("R4 not yet", int'(frm_locked), 0);
    run_cp(Q, 1, 0, "R4");
    chk("R4 locked", int'(frm_locked), 1);

    // R6 back 2 / forward 0
    write_cfg(8'h20);
    run_cp(Q, 0, 0, "R6");
    chk("R6 drop after one miss", int'(frm_locked), 0);
    acquire("R6");
    chk("R6 locked after three", int'(frm_locked), 1);

    // R9 layout change
    write_cfg(8'h13);
    run_cp(2 * Q, 1, 0, "R9");
    flip_layout();
    run_cp(3 * Q, 1, 0, "R9");
    chk("R9 held through grace", int'(frm_locked), 1);
    run_cp(2 * Q, 1, 0, "R9");
    chk("R9 dropped", int'(frm_locked), 0);
    flip_layout();
    acquire("R9");
    run_cp(6 * Q, 1, 0, "R9");
    chk("R9 hunt toggle ignored", int'(frm_locked), 1);

    // R7 hold clears state, keeps configuration
    set_hold(1);
    run_cp(6, 1, 1, "R7");
    chk("R7 held unlocked", int'(frm_locked), 0);
    chk("R7 held phase", int'(frm_phase), 0);
    set_hold(0);
    acquire("R7");
    chk("R7 relock with kept config", int'(frm_locked), 1);

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule